// File: doc/BRIEF.md
# Cascaded Interrupt Controller

This block gathers 96 interrupt sources into three 32-bit cause words and drives one interrupt line to the processor. Sources 0 to 31 are level inputs held in the main low word, and sources 32 to 63 are level inputs held in the main high word. Sources 64 to 95 come from a general-purpose port group: each input is edge-latched into the port cause word and stays set until software clears it. Four bits of the main high word (24 to 27) carry no input of their own. Each one summarises an 8-bit slice of the enabled port causes.

Each word has a full-width enable mask that the host writes through a simple register port. A vector register resolves one pending, enabled source into a 7-bit number. The low word is searched first, taking its most significant qualifying bit. The high word is searched next. When the chosen high bit is a summary bit, the search descends into the port word. Each main word passes a fixed filter of valid bit positions before the search. Reading a port vector clears that port cause bit. When nothing qualifies, the vector register returns a spurious code.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset the low mask and the port mask read 0, the high mask reads 0x0F000000, all cause words read 0, the vector register reads 0x0000007F and `cpu_irq` is 0.
- R2: Register addresses: 0 low cause, 1 high cause, 2 port cause, 3 low mask, 4 high mask, 5 port mask, 6 vector. Addresses 0 and 1 are read-only, and address 7 reads 0. The low cause word reads the level of `main_lo_src` sampled one clock earlier.
- R3: A rising edge on `port_src[n]` sets port cause bit n (source 64+n). The bit stays set after the input falls.
- R4: A write to address 2 clears each port cause bit written as 0 and leaves each bit written as 1 unchanged.
- R5: High cause bits 24+k (k=0..3) read the OR of port cause AND port mask over bits 8k..8k+7. The `main_hi_src` inputs at bits 24 to 27 have no effect. The other high cause bits follow `main_hi_src` one clock later.
- R6: Vector resolution considers only low cause bits set in 0x3DFFFFFE and high cause bits set in 0x0F000DB7.
- R7: An enabled, valid low bit takes priority over any high bit. Within a word, the most significant enabled, valid pending bit is chosen. A low bit n gives vector n, and a high bit n below 24 gives vector 32+n.
- R8: When the chosen high bit is 24 or above, the vector is 64 plus the index of the most significant bit of port cause AND port mask.
- R9: A read of address 6 that returns a port vector clears that port cause bit on the same clock edge.
- R10: The vector register reads bit 7 = valid and bits 6:0 = vector. When nothing qualifies, it reads valid 0 and vector 0x7F.
- R11: `cpu_irq` is 1 exactly when some low or high cause bit is pending, enabled and valid.
- R12: Mask registers are written as full words and read back exactly as written. A mask bit of 0 removes that source from the vector and from `cpu_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_lo_src | input | 32 | Level sources 0..31 |
| main_hi_src | input | 32 | Level sources 32..63 (bits 24..27 unused) |
| port_src | input | 32 | Edge sources 64..95 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on the vector address) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench sweeps a single pending source across every bit of each word. A filter with wrong constants, or an off-by-one in the vector offset, would then return the wrong vector or a vector where the spurious code belongs. Patterns from a shift-register generator, with mixed masks, stress the ordering between words and within a word. An encoder that picks the lowest bit, or that lets the high word beat the low word, gives a vector that differs from the arithmetic model. Port tests cover edge latching after the input falls, write-zero clearing, clearing on a vector read, and a summary disabled in the high mask. A design that clears on level, inverts the write sense or clears the wrong bit leaves a cause word that does not match. Finally, the `main_hi_src` inputs at the summary positions are driven to show they have no effect.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int WORD_W = 32;
  localparam int VEC_W  = 7;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam logic [VEC_W-1:0] VEC_NONE = {VEC_W{1'b1}};

  typedef enum logic [2:0] {
    A_LO_CAUSE   = 3'd0,
    A_HI_CAUSE   = 3'd1,
    A_PORT_CAUSE = 3'd2,
    A_LO_MASK    = 3'd3,
    A_HI_MASK    = 3'd4,
    A_PORT_MASK  = 3'd5,
    A_VECTOR     = 3'd6
  } cic_addr_e;
endpackage

// File: rtl/cic_prio_msb.sv
module cic_prio_msb #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cic_port_group.sv
module cic_port_group #(
  parameter int W       = 32,
  parameter int SUM_CNT = 4,
  parameter int IW      = $clog2(W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       src,
  input  logic [W-1:0]       mask,
  input  logic               wr_en,
  input  logic [W-1:0]       wr_keep,
  input  logic               vec_clr_en,
  input  logic [IW-1:0]      vec_clr_idx,
  output logic [W-1:0]       cause,
  output logic [SUM_CNT-1:0] summary
);
  localparam int SLICE_W = W / SUM_CNT;

  logic [W-1:0] src_q;
  logic [W-1:0] rise;
  logic [W-1:0] keep;
  logic [W-1:0] cause_d;
  logic         cause_en;
  logic [W-1:0] pend;

  assign rise = src & ~src_q;

  always_comb begin
    keep = '1;
    if (wr_en) keep = wr_keep;
    if (vec_clr_en) keep[vec_clr_idx] = 1'b0;
    cause_d  = (cause & keep) | rise;
    cause_en = wr_en | vec_clr_en | (|rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      cause <= '0;
    end else begin
      src_q <= src;
      if (cause_en) cause <= cause_d;
    end
  end

  assign pend = cause & mask;

  for (genvar k = 0; k < SUM_CNT; k++) begin : g_slice
    assign summary[k] = |pend[k*SLICE_W +: SLICE_W];
  end
endmodule

// File: rtl/cic_vector_resolve.sv
module cic_vector_resolve #(
  parameter int W       = 32,
  parameter int VW      = 7,
  parameter int SUM_LSB = 24,
  parameter int IW      = $clog2(W)
) (
  input  logic [W-1:0]  lo_pend,
  input  logic [W-1:0]  hi_pend,
  input  logic [W-1:0]  port_pend,
  output logic          valid,
  output logic [VW-1:0] vec,
  output logic          is_port,
  output logic [IW-1:0] port_idx
);
  logic          lo_hit, hi_hit, pt_hit;
  logic [IW-1:0] lo_idx, hi_idx;

  cic_prio_msb #(.W(W), .IW(IW)) u_lo (.req(lo_pend),   .found(lo_hit), .idx(lo_idx));
  cic_prio_msb #(.W(W), .IW(IW)) u_hi (.req(hi_pend),   .found(hi_hit), .idx(hi_idx));
  cic_prio_msb #(.W(W), .IW(IW)) u_pt (.req(port_pend), .found(pt_hit), .idx(port_idx));

  always_comb begin
    valid   = 1'b0;
    vec     = {VW{1'b1}};
    is_port = 1'b0;
    if (lo_hit) begin
      valid = 1'b1;
      vec   = VW'(lo_idx);
    end else if (hi_hit) begin
      if (int'(hi_idx) >= SUM_LSB) begin
        if (pt_hit) begin
          valid   = 1'b1;
          is_port = 1'b1;
          vec     = VW'(2 * W) + VW'(port_idx);
        end
      end else begin
        valid = 1'b1;
        vec   = VW'(W) + VW'(hi_idx);
      end
    end
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cic_pkg::*;
#(
  parameter logic [31:0] LO_VALID     = 32'h3DFF_FFFE,
  parameter logic [31:0] HI_VALID     = 32'h0F00_0DB7,
  parameter logic [31:0] HI_MASK_INIT = 32'h0F00_0000,
  parameter int          SUM_LSB      = 24,
  parameter int          SUM_CNT      = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] main_lo_src,
  input  logic [31:0] main_hi_src,
  input  logic [31:0] port_src,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cpu_irq
);
  localparam logic [WORD_W-1:0] SUM_FIELD =
    WORD_W'({SUM_CNT{1'b1}}) << SUM_LSB;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // level cause capture
  logic [WORD_W-1:0] lo_lvl_q, hi_lvl_q, hi_lvl_d;
  assign hi_lvl_d = main_hi_src & ~SUM_FIELD;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lo_lvl_q <= '0;
      hi_lvl_q <= '0;
    end else begin
      lo_lvl_q <= main_lo_src;
      hi_lvl_q <= hi_lvl_d;
    end
  end

  // masks: next state
  logic [WORD_W-1:0] lo_mask_q, hi_mask_q, port_mask_q;
  logic [WORD_W-1:0] lo_mask_d, hi_mask_d, port_mask_d;
  logic              lo_mask_en, hi_mask_en, port_mask_en;

  always_comb begin
    lo_mask_en   = reg_wr && (reg_addr == A_LO_MASK);
    hi_mask_en   = reg_wr && (reg_addr == A_HI_MASK);
    port_mask_en = reg_wr && (reg_addr == A_PORT_MASK);
    lo_mask_d    = reg_wdata;
    hi_mask_d    = reg_wdata;
    port_mask_d  = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lo_mask_q   <= '0;
      hi_mask_q   <= HI_MASK_INIT;
      port_mask_q <= '0;
    end else begin
      if (lo_mask_en)   lo_mask_q   <= lo_mask_d;
      if (hi_mask_en)   hi_mask_q   <= hi_mask_d;
      if (port_mask_en) port_mask_q <= port_mask_d;
    end
  end

  // port group
  logic [WORD_W-1:0]  port_cause;
  logic [SUM_CNT-1:0] port_sum;
  logic               port_wr;
  logic               vec_valid, vec_is_port, vec_clr;
  logic [VEC_W-1:0]   vec_num;
  logic [IDX_W-1:0]   vec_port_idx;

  assign port_wr = reg_wr && (reg_addr == A_PORT_CAUSE);
  assign vec_clr = reg_rd && (reg_addr == A_VECTOR) && vec_is_port;

  cic_port_group #(.W(WORD_W), .SUM_CNT(SUM_CNT), .IW(IDX_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .src         (port_src),
    .mask        (port_mask_q),
    .wr_en       (port_wr),
    .wr_keep     (reg_wdata),
    .vec_clr_en  (vec_clr),
    .vec_clr_idx (vec_port_idx),
    .cause       (port_cause),
    .summary     (port_sum)
  );

  // main words with summary inserted
  logic [WORD_W-1:0] hi_cause;
  logic [WORD_W-1:0] lo_pend, hi_pend, port_pend;

  assign hi_cause  = hi_lvl_q | (WORD_W'(port_sum) << SUM_LSB);
  assign lo_pend   = lo_lvl_q & lo_mask_q & LO_VALID;
  assign hi_pend   = hi_cause & hi_mask_q & HI_VALID;
  assign port_pend = port_cause & port_mask_q;

  cic_vector_resolve #(.W(WORD_W), .VW(VEC_W), .SUM_LSB(SUM_LSB), .IW(IDX_W)) u_res (
    .lo_pend   (lo_pend),
    .hi_pend   (hi_pend),
    .port_pend (port_pend),
    .valid     (vec_valid),
    .vec       (vec_num),
    .is_port   (vec_is_port),
    .port_idx  (vec_port_idx)
  );

  assign cpu_irq = (|lo_pend) | (|hi_pend);

  // read mux
  always_comb begin
    case (reg_addr)
      A_LO_CAUSE:   reg_rdata = lo_lvl_q;
      A_HI_CAUSE:   reg_rdata = hi_cause;
      A_PORT_CAUSE: reg_rdata = port_cause;
      A_LO_MASK:    reg_rdata = lo_mask_q;
      A_HI_MASK:    reg_rdata = hi_mask_q;
      A_PORT_MASK:  reg_rdata = port_mask_q;
      A_VECTOR:     reg_rdata = {{(WORD_W-VEC_W-1){1'b0}}, vec_valid, vec_num};
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cic_checker.sv
module cic_checker (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [2:0]  reg_addr,
  input logic [31:0] lo_pend,
  input logic [31:0] port_cause,
  input logic [31:0] port_mask_q,
  input logic [31:0] lo_mask_q,
  input logic        vec_valid,
  input logic [6:0]  vec_num,
  input logic        cpu_irq
);
  // R11 with R8: a raised line always resolves to a real vector
  assert_irq_has_vector_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_irq |-> vec_valid);

  // R10: an invalid read always carries the spurious code
  assert_spurious_code_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !vec_valid |-> (vec_num == 7'h7F));

  // R3: port cause bits only fall on a clearing write or a vector read
  assert_port_sticky_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(reg_wr && reg_addr == 3'd2) && !(reg_rd && reg_addr == 3'd6)
    |=> ((port_cause & $past(port_cause)) == $past(port_cause)));

  // R12: the low mask changes only on its own write
  assert_mask_hold_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(reg_wr && reg_addr == 3'd3) |=> $stable(lo_mask_q));

  // R7: a qualifying low bit yields a low-range vector
  assert_low_first_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lo_pend != 32'd0) |-> (vec_valid && vec_num < 7'd32));

  // R8: a port vector names an enabled, pending port bit
  assert_port_vec_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec_valid && vec_num >= 7'd64) |-> (port_cause[vec_num[4:0]] && port_mask_q[vec_num[4:0]]));
endmodule

bind cascade_irq_ctrl cic_checker u_cic_checker (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .lo_pend     (lo_pend),
  .port_cause  (port_cause),
  .port_mask_q (port_mask_q),
  .lo_mask_q   (lo_mask_q),
  .vec_valid   (vec_valid),
  .vec_num     (vec_num),
  .cpu_irq     (cpu_irq)
);

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] main_lo_src, main_hi_src, port_src;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cpu_irq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  cascade_irq_ctrl i_cascade_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .main_lo_src(main_lo_src), .main_hi_src(main_hi_src),
    .port_src(port_src), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  // bench copies of host-visible state
  logic [31:0] m_lm, m_hm, m_pm, m_pc;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // arithmetic model of the vector register
  function automatic logic [31:0] model_vec(input logic [31:0] lo, hi_in, pc, lm, hm, pm);
    logic [31:0] pp, hi, lp, hp;
    pp = pc & pm;
    hi = hi_in & 32'hF0FF_FFFF;
    for (int k = 0; k < 4; k++) hi[24+k] = |pp[8*k +: 8];
    lp = lo & lm & 32'h3DFF_FFFE;
    hp = hi & hm & 32'h0F00_0DB7;
    for (int i = 31; i >= 0; i--) if (lp[i]) return 32'h80 | i;
    for (int i = 31; i >= 0; i--) begin
      if (hp[i]) begin
        if (i < 24) return 32'h80 | (32 + i);
        for (int j = 31; j >= 0; j--) if (pp[j]) return 32'h80 | (64 + j);
        return 32'h7F;
      end
    end
    return 32'h7F;
  endfunction

  function automatic logic model_irq(input logic [31:0] lo, hi_in, pc, lm, hm, pm);
    logic [31:0] pp, hi;
    pp = pc & pm;
    hi = hi_in & 32'hF0FF_FFFF;
    for (int k = 0; k < 4; k++) hi[24+k] = |pp[8*k +: 8];
    return |((lo & lm & 32'h3DFF_FFFE) | (hi & hm & 32'h0F00_0DB7));
  endfunction

  task automatic setmasks(input logic [31:0] l, h, p);
    wr(3'd3, l); wr(3'd4, h); wr(3'd5, p);
    m_lm = l; m_hm = h; m_pm = p;
  endtask

  task automatic pulse_port(input logic [31:0] bits);
    @(negedge clk); port_src = bits;
    @(negedge clk); port_src = '0;
    m_pc = m_pc | bits;
  endtask

  task automatic chk_vec(input string req);
    logic [31:0] d;
    @(negedge clk);
    check({req, " irq"}, {31'd0, cpu_irq},
          {31'd0, model_irq(main_lo_src, main_hi_src, m_pc, m_lm, m_hm, m_pm)});
    reg_addr = 3'd6;
    #1 d = reg_rdata;
    check(req, d, model_vec(main_lo_src, main_hi_src, m_pc, m_lm, m_hm, m_pm));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, lfsr, exp_v, pat;
    rst_n = 1'b0; main_lo_src = '0; main_hi_src = '0; port_src = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_lm = '0; m_hm = 32'h0F00_0000; m_pm = '0; m_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd3, d); check("R1 lo mask", d, 32'h0);
    rd(3'd4, d); check("R1 hi mask", d, 32'h0F00_0000);
    rd(3'd5, d); check("R1 port mask", d, 32'h0);
    rd(3'd0, d); check("R1 lo cause", d, 32'h0);
    rd(3'd1, d); check("R1 hi cause", d, 32'h0);
    rd(3'd2, d); check("R1 port cause", d, 32'h0);
    rd(3'd6, d); check("R1 vector", d, 32'h7F);
    check("R1 irq", {31'd0, cpu_irq}, 32'd0);
    rd(3'd7, d); check("R2 unused addr", d, 32'h0);

    // R12 mask write/readback
    setmasks(32'hA5A5_1234, 32'h5A5A_8765, 32'hDEAD_BEEF);
    rd(3'd3, d); check("R12 lo mask", d, 32'hA5A5_1234);
    rd(3'd4, d); check("R12 hi mask", d, 32'h5A5A_8765);
    rd(3'd5, d); check("R12 port mask", d, 32'hDEAD_BEEF);

    // R2/R6/R7/R11: single low bit sweep
    setmasks(32'hFFFF_FFFF, 32'h0, 32'h0);
    for (int n = 0; n < 32; n++) begin
      @(negedge clk); main_lo_src = 32'h1 << n;
      @(negedge clk);
      rd(3'd0, d); check("R2 lo level", d, 32'h1 << n);
      chk_vec("R6 lo sweep");
    end
    main_lo_src = '0;

    // R5/R6/R7: single high bit sweep; summary inputs have no effect
    setmasks(32'h0, 32'hFFFF_FFFF, 32'h0);
    for (int n = 0; n < 32; n++) begin
      @(negedge clk); main_hi_src = 32'h1 << n;
      @(negedge clk);
      rd(3'd1, d); check("R5 hi level", d, (32'h1 << n) & 32'hF0FF_FFFF);
      chk_vec("R6 hi sweep");
    end
    main_hi_src = '0;

    // R7/R12/R11: mixed patterns with varied masks
    lfsr = 32'hACE1_2345;
    for (int t = 0; t < 48; t++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      @(negedge clk);
      main_lo_src = (t % 3 == 0) ? 32'h0 : lfsr & {lfsr[15:0], lfsr[31:16]} & 32'h0F0F_0F0F;
      main_hi_src = ~lfsr;
      setmasks(lfsr ^ 32'h0F0F_FFFF, {lfsr[7:0], lfsr[31:8]}, 32'h0);
      chk_vec("R7 mixed");
    end
    main_lo_src = '0; main_hi_src = '0;

    // R3/R5/R8/R9/R10: port sweep
    setmasks(32'h0, 32'h0F00_0000, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      pulse_port(32'h1 << n);
      rd(3'd2, d); check("R3 port latch", d, 32'h1 << n);
      rd(3'd1, d); check("R5 summary", d, 32'h0100_0000 << (n / 8));
      chk_vec("R8 port vec");
      rd(3'd6, d); check("R9 vec read", d, 32'h80 | (64 + n));
      m_pc = '0;
      rd(3'd2, d); check("R9 cleared", d, 32'h0);
      chk_vec("R10 after clear");
    end

    // R8/R9: MSB order inside the port word
    pulse_port(32'h0002_0008);
    rd(3'd6, d); check("R8 port msb", d, 32'h80 | 81);
    rd(3'd6, d); check("R9 next port", d, 32'h80 | 67);
    rd(3'd6, d); check("R10 empty", d, 32'h7F);
    m_pc = '0;

    // R4: write-zero clears, write-one keeps
    pat = 32'h0F0F_00F1;
    pulse_port(pat);
    wr(3'd2, 32'hFF00_FF0F);
    m_pc = pat & 32'hFF00_FF0F;
    rd(3'd2, d); check("R4 write clear", d, m_pc);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R4 write ones", d, m_pc);
    wr(3'd2, 32'h0); m_pc = '0;

    // R12/R10: masked port bit and disabled summary stay silent
    setmasks(32'h0, 32'h0F00_0000, 32'hFFFF_FFFB);
    pulse_port(32'h4);
    chk_vec("R12 port masked");
    rd(3'd1, d); check("R5 masked summary", d, 32'h0);
    setmasks(32'h0, 32'h0E00_0000, 32'hFFFF_FFFF);
    chk_vec("R10 summary disabled");
    @(negedge clk); main_hi_src = 32'h0F00_0020;
    @(negedge clk);
    chk_vec("R7 hi under summary");
    setmasks(32'h0, 32'h0F00_0020, 32'hFFFF_FFFF);
    chk_vec("R8 summary wins");
    @(negedge clk); main_lo_src = 32'h0000_0010;
    setmasks(32'h10, 32'h0F00_0020, 32'hFFFF_FFFF);
    exp_v = 32'h80 | 4;
    rd(3'd6, d); check("R7 low over port", d, exp_v);
    rd(3'd2, d); check("R9 no clear on low", d, 32'h4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule